// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits beside the instruction sequencer of an 8-bit processor and runs the interrupt acknowledge. Each time the core reaches the end of an instruction it raises a boundary strobe. If the sequencer is idle at that strobe and an interrupt is pending, it accepts that interrupt. It then drives the bus cycles of the acknowledge with a fixed T-state budget, one clock per T-state, and returns the new program counter and stack pointer for the core to load.

There are two kinds of interrupt:

- **Non-maskable.** It is edge-triggered and always wins over a maskable request.
- **Maskable.** It is a level request. It is taken only while the enable flag is set. It is vectored in one of three ways:
  - a fixed restart address;
  - an opcode byte read from the data bus and handed to the decoder;
  - an indirect read through a 256-byte-page vector table addressed by the interrupt page register.

The block also keeps the main enable flag and its shadow copy. The core updates them through enable, disable and return-from-NMI strobes. The return-from-NMI strobe delays maskable interrupts by one instruction.

Bus handshake:

- Each machine cycle holds `bus_op`, `bus_addr` and `bus_wdata` steady for its whole length.
- `bus_strobe` is high in its last T-state.
- A write commits at that strobe, and read data on `data_in` is sampled at that strobe.

Top module: `irq_ack_seq`

## Requirements
- R1: After synchronous reset the block is idle:
  - `busy`, `done`, `bus_strobe` and `opcode_valid` are 0;
  - `bus_op` is 00;
  - `iff1`, `iff2`, `pc_out`, `sp_out` and `opcode_out` are all 0.
- R2: A rising edge on `nmi` is latched until the sequencer accepts it.
  - A held-high `nmi` does not retrigger.
  - When the NMI and a maskable request are both pending at the same boundary, the NMI is taken.
  - The NMI is taken whatever the value of `iff1`.
- R3: The NMI sequence lasts 11 busy cycles: an internal cycle of 5 with `bus_op`=00, then two writes of 3.
  - `iff2` takes the old `iff1`, and `iff1` clears.
  - `done` pulses for one cycle with `pc_out`=0x0066 and `sp_out`=SP-2.
- R4: The stack push puts the old PC on the stack in two write cycles (`bus_op`=10).
  - The first write puts the PC high byte at SP-1, and the second puts the PC low byte at SP-2.
  - `bus_strobe` is high only in the last T-state of each bus cycle.
- R5: In maskable mode 1 (`im_sel`=01, and also for 11) the sequence lasts 13 busy cycles.
  - It starts with an acknowledge cycle of 7 (`bus_op`=01, address = PC), followed by the push.
  - Both enable flags clear, `pc_out`=0x0038 and `sp_out`=SP-2.
- R6: In mode 2 (`im_sel`=10) the sequence lasts 19 busy cycles.
  - The byte V read during the acknowledge cycle forms the pointer {I, V[7:1], 0}.
  - After the push come two reads (`bus_op`=11): the first at the pointer (target low byte), the second at pointer+1 (target high byte).
  - `pc_out` is the target.
- R7: In mode 0 (`im_sel`=00) the sequence lasts only the 7-cycle acknowledge cycle, with no push.
  - The byte on `data_in` at its strobe appears on `opcode_out`, and `opcode_valid` pulses together with `done`.
  - `pc_out` and `sp_out` return the PC and SP captured at acceptance.
- R8: A maskable request is accepted only at a boundary strobe while `iff1`=1. A boundary strobe during a sequence is ignored.
- R9: `ei` sets both enable flags and `di` clears both; `di` wins when both are raised.
- R10: `retn` copies `iff2` into `iff1`. It also blocks maskable acceptance at the next idle boundary strobe, the one ending the return instruction. NMI acceptance is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| int_req | input | 1 | Maskable request, level sensitive |
| boundary | input | 1 | Instruction-boundary strobe |
| ei | input | 1 | Enable-interrupts strobe |
| di | input | 1 | Disable-interrupts strobe |
| retn | input | 1 | Return-from-NMI strobe |
| im_sel | input | 2 | Maskable vectoring mode |
| i_reg | input | 8 | Vector table page |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| data_in | input | 8 | Read data and acknowledge byte |
| busy | output | 1 | Sequence in progress |
| bus_op | output | 2 | 00 none, 01 acknowledge, 10 write, 11 read |
| bus_addr | output | 16 | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_strobe | output | 1 | Last T-state of a bus cycle |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| opcode_out | output | 8 | Mode-0 opcode for the decoder |
| opcode_valid | output | 1 | Mode-0 opcode present |
| iff1 | output | 1 | Interrupt enable flag |
| iff2 | output | 1 | Shadow enable flag |

## Verification
The embedded assertions check the following on every cycle:

- the edge latch sets on a rising `nmi` and clears on acceptance;
- a phase never ends before its T-state count runs out, and the high-byte push is always followed by the low-byte push;
- the enable flags change as required on each acceptance;
- no maskable acceptance happens with `iff1` low, and no acceptance happens while busy.

The exact T-state totals of each mode, the addresses and data of every cycle, and the mode-2 indirect target need whole scenarios. The same holds for NMI-over-maskable priority, the one-boundary block after `retn`, and the non-retriggering of a held NMI. The bench shows these with a behavioural model compared every clock.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        BUS_NONE   = 2'b00,
        BUS_INTACK = 2'b01,
        BUS_WRITE  = 2'b10,
        BUS_READ   = 2'b11
    } bus_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACK,
        PH_PUSH_HI,
        PH_PUSH_LO,
        PH_VEC_LO,
        PH_VEC_HI
    } phase_e;

    typedef enum logic [1:0] {
        SRC_NMI,
        SRC_IM0,
        SRC_IM1,
        SRC_IM2
    } src_e;

    typedef struct packed {
        bus_op_e     op;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic        strobe;
    } bus_cyc_t;

    // Mode select code 11 behaves like the fixed-restart mode.
    function automatic src_e mode_to_src(input logic [1:0] im);
        case (im)
            2'b00:   return SRC_IM0;
            2'b10:   return SRC_IM2;
            default: return SRC_IM1;
        endcase
    endfunction

    // Phase that follows 'p' once its T-states are used up.
    function automatic phase_e next_phase(input src_e s, input phase_e p);
        case (p)
            PH_ACK:     return (s == SRC_IM0) ? PH_IDLE : PH_PUSH_HI;
            PH_PUSH_HI: return PH_PUSH_LO;
            PH_PUSH_LO: return (s == SRC_IM2) ? PH_VEC_LO : PH_IDLE;
            PH_VEC_LO:  return PH_VEC_HI;
            default:    return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic take_nmi,
    output logic pending
);
    logic nmi_d;
    logic rise;

    assign rise = nmi_in && !nmi_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_d   <= 1'b0;
            pending <= 1'b0;
        end else begin
            nmi_d <= nmi_in;
            if (rise)          pending <= 1'b1;
            else if (take_nmi) pending <= 1'b0;
        end
    end

    p_nmi_set_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> pending);
    p_nmi_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (take_nmi && !rise) |=> !pending);

endmodule

// File: rtl/irq_iff_ctrl.sv
module irq_iff_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ei,
    input  logic di,
    input  logic retn,
    input  logic boundary_idle,
    input  logic take_nmi,
    input  logic take_int,
    output logic iff1,
    output logic iff2,
    output logic int_block
);
    logic inhibit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            iff1      <= 1'b0;
            iff2      <= 1'b0;
            inhibit_q <= 1'b0;
        end else begin
            if (take_nmi) begin
                iff2 <= iff1;
                iff1 <= 1'b0;
            end else if (take_int || di) begin
                iff1 <= 1'b0;
                iff2 <= 1'b0;
            end else if (ei) begin
                iff1 <= 1'b1;
                iff2 <= 1'b1;
            end else if (retn) begin
                iff1 <= iff2;
            end

            if (boundary_idle) inhibit_q <= 1'b0;
            else if (retn)     inhibit_q <= 1'b1;
        end
    end

    // The strobe itself also blocks, so a return and its boundary may coincide.
    assign int_block = inhibit_q || retn;

    p_iff_nmi_save_r3: assert property (@(posedge clk) disable iff (rst)
        take_nmi |=> (iff2 == $past(iff1)) && !iff1);
    p_iff_int_clear_r5: assert property (@(posedge clk) disable iff (rst)
        take_int |=> !iff1 && !iff2);
    p_iff_ei_r9: assert property (@(posedge clk) disable iff (rst)
        (ei && !di && !take_nmi && !take_int) |=> iff1 && iff2);
    p_iff_di_r9: assert property (@(posedge clk) disable iff (rst)
        di |=> !iff1 && !iff2);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_ack_pkg::*;
#(
    parameter int unsigned T_NMI_ACK  = 5,
    parameter int unsigned T_INT_ACK  = 7,
    parameter int unsigned T_MEM      = 3,
    parameter logic [15:0] NMI_TARGET = 16'h0066,
    parameter logic [15:0] IM1_TARGET = 16'h0038
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary,
    input  logic        nmi_pend,
    input  logic        int_req,
    input  logic        int_ok,
    input  logic [1:0]  im_sel,
    input  logic [7:0]  i_reg,
    input  logic [15:0] pc_in,
    input  logic [15:0] sp_in,
    input  logic [7:0]  data_in,
    output logic        take_nmi,
    output logic        take_int,
    output logic        busy,
    output bus_cyc_t    bus,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic [7:0]  opcode_out,
    output logic        opcode_valid
);
    localparam int unsigned TMAX_A = (T_NMI_ACK > T_INT_ACK) ? T_NMI_ACK : T_INT_ACK;
    localparam int unsigned TMAX   = (TMAX_A > T_MEM) ? TMAX_A : T_MEM;
    localparam int unsigned TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] TC_NMI = TW'(T_NMI_ACK - 1);
    localparam logic [TW-1:0] TC_INT = TW'(T_INT_ACK - 1);
    localparam logic [TW-1:0] TC_MEM = TW'(T_MEM - 1);

    phase_e        phase_q, phase_nx;
    src_e          src_q;
    logic [TW-1:0] tcnt_q;
    logic [15:0]   pc_q, sp_q;
    logic [7:0]    i_q, vec_q, tlo_q;
    logic          idle;

    assign idle     = (phase_q == PH_IDLE);
    assign busy     = !idle;
    assign take_nmi = idle && boundary && nmi_pend;
    assign take_int = idle && boundary && !nmi_pend && int_req && int_ok;
    assign phase_nx = next_phase(src_q, phase_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            src_q        <= SRC_NMI;
            tcnt_q       <= '0;
            pc_q         <= '0;
            sp_q         <= '0;
            i_q          <= '0;
            vec_q        <= '0;
            tlo_q        <= '0;
            done         <= 1'b0;
            pc_out       <= '0;
            sp_out       <= '0;
            opcode_out   <= '0;
            opcode_valid <= 1'b0;
        end else begin
            done         <= 1'b0;
            opcode_valid <= 1'b0;
            if (idle) begin
                if (take_nmi || take_int) begin
                    src_q   <= take_nmi ? SRC_NMI : mode_to_src(im_sel);
                    pc_q    <= pc_in;
                    sp_q    <= sp_in;
                    i_q     <= i_reg;
                    phase_q <= PH_ACK;
                    tcnt_q  <= take_nmi ? TC_NMI : TC_INT;
                end
            end else if (tcnt_q != '0) begin
                tcnt_q <= tcnt_q - TW'(1);
            end else begin
                if (phase_q == PH_ACK)    vec_q <= data_in;
                if (phase_q == PH_VEC_LO) tlo_q <= data_in;
                phase_q <= phase_nx;
                tcnt_q  <= TC_MEM;
                if (phase_nx == PH_IDLE) begin
                    done   <= 1'b1;
                    sp_out <= (src_q == SRC_IM0) ? sp_q : sp_q - 16'd2;
                    case (src_q)
                        SRC_NMI: pc_out <= NMI_TARGET;
                        SRC_IM1: pc_out <= IM1_TARGET;
                        SRC_IM2: pc_out <= {data_in, tlo_q};
                        default: begin
                            pc_out       <= pc_q;
                            opcode_out   <= data_in;
                            opcode_valid <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_comb begin
        bus.op    = BUS_NONE;
        bus.addr  = '0;
        bus.wdata = '0;
        case (phase_q)
            PH_ACK: begin
                if (src_q != SRC_NMI) begin
                    bus.op   = BUS_INTACK;
                    bus.addr = pc_q;
                end
            end
            PH_PUSH_HI: begin
                bus.op    = BUS_WRITE;
                bus.addr  = sp_q - 16'd1;
                bus.wdata = pc_q[15:8];
            end
            PH_PUSH_LO: begin
                bus.op    = BUS_WRITE;
                bus.addr  = sp_q - 16'd2;
                bus.wdata = pc_q[7:0];
            end
            PH_VEC_LO: begin
                bus.op   = BUS_READ;
                bus.addr = {i_q, vec_q[7:1], 1'b0};
            end
            PH_VEC_HI: begin
                bus.op   = BUS_READ;
                bus.addr = {i_q, vec_q[7:1], 1'b1};
            end
            default: ;
        endcase
        bus.strobe = (bus.op != BUS_NONE) && (tcnt_q == '0);
    end

    p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!idle && tcnt_q != '0) |=> (phase_q == $past(phase_q)));
    p_push_order_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PUSH_HI && tcnt_q == '0) |=> (phase_q == PH_PUSH_LO));
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_vec_order_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_VEC_LO && tcnt_q == '0) |=> (phase_q == PH_VEC_HI));

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int unsigned T_NMI_ACK  = 5,
    parameter int unsigned T_INT_ACK  = 7,
    parameter int unsigned T_MEM      = 3,
    parameter logic [15:0] NMI_TARGET = 16'h0066,
    parameter logic [15:0] IM1_TARGET = 16'h0038
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        nmi,
    input  logic        int_req,
    input  logic        boundary,
    input  logic        ei,
    input  logic        di,
    input  logic        retn,
    input  logic [1:0]  im_sel,
    input  logic [7:0]  i_reg,
    input  logic [15:0] pc_in,
    input  logic [15:0] sp_in,
    input  logic [7:0]  data_in,
    output logic        busy,
    output logic [1:0]  bus_op,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_strobe,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic [7:0]  opcode_out,
    output logic        opcode_valid,
    output logic        iff1,
    output logic        iff2
);
    logic     nmi_pend, take_nmi, take_int, int_block;
    bus_cyc_t bus;

    irq_nmi_latch u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_in   (nmi),
        .take_nmi (take_nmi),
        .pending  (nmi_pend)
    );

    irq_iff_ctrl u_iff (
        .clk           (clk),
        .rst           (rst),
        .ei            (ei),
        .di            (di),
        .retn          (retn),
        .boundary_idle (boundary && !busy),
        .take_nmi      (take_nmi),
        .take_int      (take_int),
        .iff1          (iff1),
        .iff2          (iff2),
        .int_block     (int_block)
    );

    irq_seq_fsm #(
        .T_NMI_ACK  (T_NMI_ACK),
        .T_INT_ACK  (T_INT_ACK),
        .T_MEM      (T_MEM),
        .NMI_TARGET (NMI_TARGET),
        .IM1_TARGET (IM1_TARGET)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .boundary     (boundary),
        .nmi_pend     (nmi_pend),
        .int_req      (int_req),
        .int_ok       (iff1 && !int_block),
        .im_sel       (im_sel),
        .i_reg        (i_reg),
        .pc_in        (pc_in),
        .sp_in        (sp_in),
        .data_in      (data_in),
        .take_nmi     (take_nmi),
        .take_int     (take_int),
        .busy         (busy),
        .bus          (bus),
        .done         (done),
        .pc_out       (pc_out),
        .sp_out       (sp_out),
        .opcode_out   (opcode_out),
        .opcode_valid (opcode_valid)
    );

    assign bus_op     = bus.op;
    assign bus_addr   = bus.addr;
    assign bus_wdata  = bus.wdata;
    assign bus_strobe = bus.strobe;

    p_int_needs_iff1_r8: assert property (@(posedge clk) disable iff (rst)
        take_int |-> iff1);
    p_busy_no_take_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !take_nmi && !take_int);
    p_retn_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        (retn && boundary) |-> !take_int);

endmodule

// File: tb/irq_ack_seq_tb.sv
module irq_ack_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi = 1'b0, int_req = 1'b0, boundary = 1'b0;
    logic        ei = 1'b0, di = 1'b0, retn = 1'b0;
    logic [1:0]  im_sel = 2'b01;
    logic [7:0]  i_reg = 8'h00, vec_b = 8'h00;
    logic [15:0] pc_in = 16'h0000, sp_in = 16'h0000;
    logic [7:0]  data_in;
    logic        busy, bus_strobe, done, opcode_valid, iff1, iff2;
    logic [1:0]  bus_op;
    logic [15:0] bus_addr, pc_out, sp_out;
    logic [7:0]  bus_wdata, opcode_out;

    int ntests = 0;
    int nfail  = 0;
    logic started = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign data_in = (bus_op == 2'b01) ? vec_b : mem_byte(bus_addr);

    irq_ack_seq u_dut (
        .clk(clk), .rst(rst), .nmi(nmi), .int_req(int_req), .boundary(boundary),
        .ei(ei), .di(di), .retn(retn), .im_sel(im_sel), .i_reg(i_reg),
        .pc_in(pc_in), .sp_in(sp_in), .data_in(data_in), .busy(busy),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_strobe(bus_strobe), .done(done), .pc_out(pc_out), .sp_out(sp_out),
        .opcode_out(opcode_out), .opcode_valid(opcode_valid), .iff1(iff1), .iff2(iff2)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        logic        busy;
        logic [1:0]  op;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic        stb;
        logic        last;
        string       tag;
    } rec_t;

    rec_t  q[$];
    rec_t  cur;
    logic  m_prev, m_pend, m_iff1, m_iff2, m_inh;
    logic  m_done, m_opv;
    logic [15:0] m_pc, m_sp, r_pc, r_sp;
    logic [7:0]  m_opc, r_opc;
    logic  r_m0;
    string res_tag = "R1";
    string iff_tag = "R1";

    function automatic rec_t idle_rec();
        rec_t r;
        r.busy = 0; r.op = 0; r.addr = 0; r.wd = 0; r.stb = 0; r.last = 0; r.tag = "R8";
        return r;
    endfunction

    task automatic add_cycle(input logic [1:0] op, input logic [15:0] a, input logic [7:0] wd,
                             input int n, input logic last, input string tag);
        for (int k = 0; k < n; k++) begin
            rec_t r;
            r.busy = 1; r.op = op; r.addr = a; r.wd = wd;
            r.stb  = (op != 2'b00) && (k == n - 1);
            r.last = last && (k == n - 1);
            r.tag  = tag;
            q.push_back(r);
        end
    endtask

    task automatic build(input logic is_nmi);
        logic [15:0] ptr;
        int mode;
        mode = is_nmi ? 4 : ((im_sel == 2'b00) ? 0 : ((im_sel == 2'b10) ? 2 : 1));
        r_m0 = 0;
        if (mode == 4) begin
            add_cycle(2'b00, 16'h0, 8'h0, 5, 0, "R3");
            add_cycle(2'b10, sp_in - 16'd1, pc_in[15:8], 3, 0, "R4");
            add_cycle(2'b10, sp_in - 16'd2, pc_in[7:0], 3, 1, "R4");
            r_pc = 16'h0066; r_sp = sp_in - 16'd2; res_tag = "R3";
        end else if (mode == 1) begin
            add_cycle(2'b01, pc_in, 8'h0, 7, 0, "R5");
            add_cycle(2'b10, sp_in - 16'd1, pc_in[15:8], 3, 0, "R4");
            add_cycle(2'b10, sp_in - 16'd2, pc_in[7:0], 3, 1, "R4");
            r_pc = 16'h0038; r_sp = sp_in - 16'd2; res_tag = "R5";
        end else if (mode == 2) begin
            ptr = {i_reg, vec_b[7:1], 1'b0};
            add_cycle(2'b01, pc_in, 8'h0, 7, 0, "R6");
            add_cycle(2'b10, sp_in - 16'd1, pc_in[15:8], 3, 0, "R4");
            add_cycle(2'b10, sp_in - 16'd2, pc_in[7:0], 3, 0, "R4");
            add_cycle(2'b11, ptr, 8'h0, 3, 0, "R6");
            add_cycle(2'b11, ptr + 16'd1, 8'h0, 3, 1, "R6");
            r_pc = {mem_byte(ptr + 16'd1), mem_byte(ptr)}; r_sp = sp_in - 16'd2; res_tag = "R6";
        end else begin
            add_cycle(2'b01, pc_in, 8'h0, 7, 1, "R7");
            r_pc = pc_in; r_sp = sp_in; r_m0 = 1; r_opc = vec_b; res_tag = "R7";
        end
    endtask

    always @(posedge clk) begin
        logic rise, idle, tn, ti;
        if (rst) begin
            m_prev = 0; m_pend = 0; m_iff1 = 0; m_iff2 = 0; m_inh = 0;
            m_done = 0; m_opv = 0; m_pc = 0; m_sp = 0; m_opc = 0;
            cur = idle_rec(); q.delete();
        end else begin
            rise = nmi && !m_prev;
            m_prev = nmi;
            idle = !cur.busy;
            tn = idle && boundary && m_pend;
            ti = idle && boundary && !m_pend && int_req && m_iff1 && !(m_inh || retn);
            m_done = 0; m_opv = 0;
            if (!idle) begin
                if (cur.last) begin
                    cur = idle_rec(); m_done = 1; m_pc = r_pc; m_sp = r_sp;
                    if (r_m0) begin m_opv = 1; m_opc = r_opc; end
                end else cur = q.pop_front();
            end else if (tn || ti) begin
                build(tn);
                cur = q.pop_front();
            end
            if (tn) m_pend = 0;
            if (rise) m_pend = 1;
            if (tn) begin m_iff2 = m_iff1; m_iff1 = 0; iff_tag = "R3"; end
            else if (ti) begin m_iff1 = 0; m_iff2 = 0; iff_tag = "R5"; end
            else if (di) begin m_iff1 = 0; m_iff2 = 0; iff_tag = "R9"; end
            else if (ei) begin m_iff1 = 1; m_iff2 = 1; iff_tag = "R9"; end
            else if (retn) begin m_iff1 = m_iff2; iff_tag = "R10"; end
            if (idle && boundary) m_inh = 0;
            else if (retn) m_inh = 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && started) begin
            chk(busy == cur.busy && bus_op == cur.op && bus_addr == cur.addr &&
                bus_wdata == cur.wd && bus_strobe == cur.stb, cur.tag,
                {28'h0, busy, bus_op, bus_addr, bus_wdata, bus_strobe},
                {28'h0, cur.busy, cur.op, cur.addr, cur.wd, cur.stb});
            chk(done == m_done && pc_out == m_pc && sp_out == m_sp &&
                opcode_valid == m_opv && opcode_out == m_opc, res_tag,
                {22'h0, done, opcode_valid, pc_out, sp_out, opcode_out},
                {22'h0, m_done, m_opv, m_pc, m_sp, m_opc});
            chk(iff1 == m_iff1 && iff2 == m_iff2, iff_tag,
                {62'h0, iff1, iff2}, {62'h0, m_iff1, m_iff2});
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse_ei();
        ei = 1; @(negedge clk); ei = 0; @(negedge clk);
    endtask

    task automatic run_seq(input int exp_len, input string tag);
        int cnt;
        boundary = 1;
        @(negedge clk);
        boundary = 0;
        cnt = 0;
        while (busy && cnt < 40) begin
            cnt++;
            if (cnt == 2) boundary = 1;      // strobe during a sequence: ignored (R8)
            if (cnt == 3) boundary = 0;
            @(negedge clk);
        end
        chk(cnt == exp_len, tag, 64'(cnt), 64'(exp_len));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        started = 1;
        // R1 reset state
        chk(!busy && bus_op == 2'b00 && !iff1 && !iff2 && pc_out == 0 && sp_out == 0 &&
            !done && !opcode_valid && opcode_out == 0, "R1",
            {busy, bus_op, iff1, iff2, pc_out, sp_out}, 64'h0);

        // R8: maskable request ignored while iff1=0
        int_req = 1; im_sel = 2'b01;
        for (int k = 0; k < 3; k++) begin
            boundary = 1; @(negedge clk); boundary = 0; @(negedge clk);
            chk(!busy, "R8", 64'(busy), 64'h0);
        end
        int_req = 0;

        // R9 enable
        pulse_ei();

        // R3/R4 NMI with iff1=1
        pc_in = 16'h1234; sp_in = 16'h8000;
        nmi = 1; @(negedge clk);
        run_seq(11, "R3");
        chk(pc_out == 16'h0066 && sp_out == 16'h7FFE, "R3", {pc_out, sp_out}, {16'h0066, 16'h7FFE});

        // R2: held-high NMI must not retrigger
        boundary = 1; @(negedge clk); boundary = 0; @(negedge clk);
        chk(!busy, "R2", 64'(busy), 64'h0);
        nmi = 0;

        // R10: retn restores iff1 and blocks the next boundary
        retn = 1; @(negedge clk); retn = 0;
        int_req = 1; im_sel = 2'b01; pc_in = 16'hABCD; sp_in = 16'h0001;
        boundary = 1; @(negedge clk); boundary = 0; @(negedge clk);
        chk(!busy && iff1, "R10", {62'h0, busy, iff1}, 64'h1);
        // R5 mode 1 (with SP wrap)
        run_seq(13, "R5");
        int_req = 0;

        // R6 mode 2
        pulse_ei();
        im_sel = 2'b10; i_reg = 8'h40; vec_b = 8'h37; pc_in = 16'h2468; sp_in = 16'hC000;
        int_req = 1;
        run_seq(19, "R6");
        int_req = 0;

        // R7 mode 0
        pulse_ei();
        im_sel = 2'b00; vec_b = 8'hFF; pc_in = 16'h0F0F; sp_in = 16'h5555;
        int_req = 1;
        run_seq(7, "R7");
        chk(opcode_out == 8'hFF && sp_out == 16'h5555, "R7", {opcode_out, sp_out}, {8'hFF, 16'h5555});
        int_req = 0;

        // R5 mode code 11 acts as mode 1
        pulse_ei();
        im_sel = 2'b11; pc_in = 16'h7001; sp_in = 16'h9000;
        int_req = 1;
        run_seq(13, "R5");
        int_req = 0;

        // R2 priority: NMI and maskable together
        pulse_ei();
        im_sel = 2'b01; int_req = 1; nmi = 1; pc_in = 16'h3333; sp_in = 16'h4444;
        @(negedge clk);
        run_seq(11, "R2");
        nmi = 0;
        pulse_ei();
        run_seq(13, "R5");
        int_req = 0;

        // R9: disable wins over enable
        ei = 1; di = 1; @(negedge clk); ei = 0; di = 0; @(negedge clk);
        chk(!iff1 && !iff2, "R9", {62'h0, iff1, iff2}, 64'h0);

        // R2: NMI taken with iff1=0, shadow flag stays 0
        nmi = 1; @(negedge clk);
        run_seq(11, "R2");
        chk(!iff2 && !iff1, "R3", {62'h0, iff1, iff2}, 64'h0);
        nmi = 0;
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        nfail++;
        ntests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule